// File: doc/BRIEF.md
# Dual-Clock Frequency Comparator

This block checks whether a clock under test runs at the expected rate against a reference clock. Inside the reference domain a reference counter counts down from its seed. When it reaches zero, a window counter loads the window seed and counts the acceptance window down. A measured counter in the clock-under-test domain counts down from its own seed. It must reach zero while the window is open.

Each zero of the measured counter flips a toggle. That toggle crosses into the reference domain through a synchronizer, and an edge detector turns it back into a single-cycle event. If the event arrives while the window is open, every counter reloads and the next measurement starts on its own. If the event arrives before the window opens, or the window closes with no event, a sticky fault flag is set and counting stops until software writes 1 to clear it.

All three seeds and the control bits sit behind a small register port in the reference domain. Only writes marked privileged take effect. Reads work in any mode.

Top module: `clk_cmp`

## Requirements
- R1: After reset, all three seeds, the run-enable bit and the fault flag read as 0, and `err_flag` is low.
- R2: The register port decodes four addresses on `bus_addr`:
  - 0: control, where bit 0 is run-enable and bit 1 is the fault flag.
  - 1: measured seed, 20 bits.
  - 2: reference seed, 16 bits.
  - 3: window seed, 16 bits.

  A read returns each register's current value in its low bits, and every bit above the field reads 0. Writing all-ones therefore reads back as 0x000FFFFF at address 1 and as 0x0000FFFF at addresses 2 and 3.
- R3: A write with `bus_priv` low changes no seed, no enable bit and no fault flag.
- R4: A write of 1 to the run-enable bit is refused, and the bit stays 0, unless the window seed is at least 4 and the measured seed is non-zero. A window seed of 3 is refused and a window seed of 4 is accepted.
- R5: If the measured counter reaches zero before the window opens, the fault flag is set.
- R6: If the window closes before the measured counter reaches zero, the fault flag is set.
- R7: If the measured counter reaches zero while the window is open, no fault is raised. The counters reload and measurement repeats with no software action.
- R8: The fault flag stays set until a privileged write to address 0 with bit 1 set. A write to address 0 with bit 1 clear leaves it set. `err_flag` always follows the flag.
- R9: While run-enable is 0, all counters hold at their seeds and no fault is raised. Enabling again starts a fresh measurement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock; the register port and window logic run on it |
| ref_rst_n | input | 1 | Active-low reset, reference domain |
| tst_clk | input | 1 | Clock under test |
| tst_rst_n | input | 1 | Active-low reset, clock-under-test domain |
| bus_wr | input | 1 | Write strobe |
| bus_priv | input | 1 | Marks the access as privileged |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| err_flag | output | 1 | Sticky fault flag |

## Verification
The checker assumes that the measured seed is changed only while run-enable is 0. It also assumes that the fault flag is cleared only after run-enable has been low long enough for the clock-under-test side to see the stop. The bench meets both conditions by disabling the block and then waiting about thirty reference cycles before it reprograms a seed or clears a fault.

The synchronizer adds a latency of a few cycles. Measured-seed values whose zero falls within that distance of a window edge would give an outcome that depends on clock phase. The sweep skips those values and keeps at least four reference cycles of margin on either side of each window edge.

// File: rtl/clk_cmp_pkg.sv
package clk_cmp_pkg;
   localparam int DATA_W = 32;
   localparam int ADDR_W = 2;
   localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
   localparam logic [ADDR_W-1:0] A_MEAS = 2'd1;
   localparam logic [ADDR_W-1:0] A_REF  = 2'd2;
   localparam logic [ADDR_W-1:0] A_WIN  = 2'd3;
   localparam int CTRL_EN  = 0;
   localparam int CTRL_ERR = 1;
   typedef enum logic [1:0] {PH_IDLE, PH_COUNT, PH_WIN} phase_e;
endpackage

// File: rtl/clk_cmp_sync.sv
module clk_cmp_sync #(
   parameter int STAGES = 2,
   parameter int W      = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("clk_cmp_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[i] <= '0;
            else        chain[i] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[i] <= '0;
            else        chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/clk_cmp_regs.sv
module clk_cmp_regs
   import clk_cmp_pkg::*;
#(
   parameter int MEAS_W  = 20,
   parameter int REF_W   = 16,
   parameter int WIN_W   = 16,
   parameter int MIN_WIN = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              priv,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              fault,
   output logic              en_q,
   output logic              err_q,
   output logic [MEAS_W-1:0] meas_seed,
   output logic [REF_W-1:0]  ref_seed,
   output logic [WIN_W-1:0]  win_seed
);
   localparam int MAXW = (MEAS_W > REF_W) ? ((MEAS_W > WIN_W) ? MEAS_W : WIN_W)
                                          : ((REF_W > WIN_W) ? REF_W : WIN_W);

   logic acc, cfg_ok, clr_err;
   logic unused_hi;

   assign unused_hi = ^wdata[DATA_W-1:MAXW];
   assign acc       = wr && priv;
   assign cfg_ok    = (win_seed >= WIN_W'(MIN_WIN)) && (meas_seed != '0);
   assign clr_err   = acc && (addr == A_CTRL) && wdata[CTRL_ERR];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q      <= 1'b0;
         meas_seed <= '0;
         ref_seed  <= '0;
         win_seed  <= '0;
      end else if (acc) begin
         case (addr)
            A_CTRL:  en_q      <= wdata[CTRL_EN] && cfg_ok;
            A_MEAS:  meas_seed <= wdata[MEAS_W-1:0];
            A_REF:   ref_seed  <= wdata[REF_W-1:0];
            default: win_seed  <= wdata[WIN_W-1:0];
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= fault || (err_q && !clr_err);
   end

   always_comb begin
      rdata = '0;
      case (addr)
         A_CTRL: begin
            rdata[CTRL_EN]  = en_q;
            rdata[CTRL_ERR] = err_q;
         end
         A_MEAS:  rdata[MEAS_W-1:0] = meas_seed;
         A_REF:   rdata[REF_W-1:0]  = ref_seed;
         default: rdata[WIN_W-1:0]  = win_seed;
      endcase
   end
endmodule

// File: rtl/clk_cmp_window.sv
module clk_cmp_window
   import clk_cmp_pkg::*;
#(
   parameter int REF_W = 16,
   parameter int WIN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             evt,
   input  logic [REF_W-1:0] ref_seed,
   input  logic [WIN_W-1:0] win_seed,
   output logic             fault
);
   localparam int CW = (REF_W > WIN_W) ? REF_W : WIN_W;

   phase_e        ph;
   logic [CW-1:0] cnt;
   logic          cnt_zero;

   assign cnt_zero = (cnt == '0);

   always_comb begin
      fault = 1'b0;
      if (run) begin
         if (ph == PH_COUNT && evt)                   fault = 1'b1;
         else if (ph == PH_WIN && !evt && cnt_zero)   fault = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph  <= PH_IDLE;
         cnt <= '0;
      end else if (!run) begin
         ph  <= PH_IDLE;
      end else begin
         case (ph)
            PH_IDLE: begin
               ph  <= PH_COUNT;
               cnt <= CW'(ref_seed);
            end
            PH_COUNT: begin
               if (evt)           ph <= PH_IDLE;
               else if (cnt_zero) begin
                  ph  <= PH_WIN;
                  cnt <= CW'(win_seed) - CW'(1);
               end else           cnt <= cnt - CW'(1);
            end
            default: begin
               if (evt) begin
                  ph  <= PH_COUNT;
                  cnt <= CW'(ref_seed);
               end else if (cnt_zero) ph <= PH_IDLE;
               else                   cnt <= cnt - CW'(1);
            end
         endcase
      end
   end
endmodule

// File: rtl/clk_cmp_meas.sv
module clk_cmp_meas #(
   parameter int MEAS_W      = 20,
   parameter int SYNC_STAGES = 2
) (
   input  logic              tst_clk,
   input  logic              tst_rst_n,
   input  logic              run_ref,
   input  logic [MEAS_W-1:0] seed,
   output logic              done_tgl
);
   logic              run_s;
   logic [MEAS_W-1:0] cnt;

   clk_cmp_sync #(.STAGES(SYNC_STAGES), .W(1)) u_run_sync (
      .clk(tst_clk), .rst_n(tst_rst_n), .d(run_ref), .q(run_s)
   );

   always_ff @(posedge tst_clk or negedge tst_rst_n) begin
      if (!tst_rst_n) begin
         cnt      <= '0;
         done_tgl <= 1'b0;
      end else if (!run_s) begin
         cnt      <= seed;
      end else if (cnt <= MEAS_W'(1)) begin
         cnt      <= seed;
         done_tgl <= ~done_tgl;
      end else begin
         cnt      <= cnt - MEAS_W'(1);
      end
   end
endmodule

// File: rtl/clk_cmp.sv
module clk_cmp
   import clk_cmp_pkg::*;
#(
   parameter int MEAS_W      = 20,
   parameter int REF_W       = 16,
   parameter int WIN_W       = 16,
   parameter int MIN_WIN     = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              ref_clk,
   input  logic              ref_rst_n,
   input  logic              tst_clk,
   input  logic              tst_rst_n,
   input  logic              bus_wr,
   input  logic              bus_priv,
   input  logic [1:0]        bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              err_flag
);
   if (MEAS_W < 1 || MEAS_W >= DATA_W || REF_W < 1 || REF_W >= DATA_W ||
       WIN_W < 3 || WIN_W >= DATA_W) begin : g_bad_width
      $error("clk_cmp: seed widths out of range");
   end
   if (MIN_WIN < 1 || MIN_WIN >= (1 << WIN_W)) begin : g_bad_min
      $error("clk_cmp: MIN_WIN does not fit the window seed");
   end

   logic              en_q, err_q, fault_c, run_ref;
   logic              tgl_tst, tgl_ref, tgl_ref_d, evt;
   logic [MEAS_W-1:0] meas_seed;
   logic [REF_W-1:0]  ref_seed;
   logic [WIN_W-1:0]  win_seed;

   assign run_ref  = en_q && !err_q;
   assign err_flag = err_q;

   clk_cmp_regs #(.MEAS_W(MEAS_W), .REF_W(REF_W), .WIN_W(WIN_W), .MIN_WIN(MIN_WIN)) u_regs (
      .clk(ref_clk), .rst_n(ref_rst_n), .wr(bus_wr), .priv(bus_priv),
      .addr(bus_addr), .wdata(bus_wdata), .rdata(bus_rdata), .fault(fault_c),
      .en_q(en_q), .err_q(err_q), .meas_seed(meas_seed), .ref_seed(ref_seed),
      .win_seed(win_seed)
   );

   clk_cmp_meas #(.MEAS_W(MEAS_W), .SYNC_STAGES(SYNC_STAGES)) u_meas (
      .tst_clk(tst_clk), .tst_rst_n(tst_rst_n), .run_ref(run_ref),
      .seed(meas_seed), .done_tgl(tgl_tst)
   );

   clk_cmp_sync #(.STAGES(SYNC_STAGES), .W(1)) u_done_sync (
      .clk(ref_clk), .rst_n(ref_rst_n), .d(tgl_tst), .q(tgl_ref)
   );

   always_ff @(posedge ref_clk or negedge ref_rst_n)
      if (!ref_rst_n) tgl_ref_d <= 1'b0;
      else            tgl_ref_d <= tgl_ref;

   assign evt = tgl_ref ^ tgl_ref_d;

   clk_cmp_window #(.REF_W(REF_W), .WIN_W(WIN_W)) u_win (
      .clk(ref_clk), .rst_n(ref_rst_n), .run(run_ref), .evt(evt),
      .ref_seed(ref_seed), .win_seed(win_seed), .fault(fault_c)
   );
endmodule

// File: rtl/clk_cmp_chk.sv
module clk_cmp_chk #(
   parameter int MEAS_W  = 20,
   parameter int REF_W   = 16,
   parameter int WIN_W   = 16,
   parameter int MIN_WIN = 4
) (
   input logic              ref_clk,
   input logic              ref_rst_n,
   input logic              bus_wr,
   input logic              bus_priv,
   input logic [1:0]        bus_addr,
   input logic [31:0]       bus_wdata,
   input logic              en_q,
   input logic              err_q,
   input logic              fault_c,
   input logic [MEAS_W-1:0] meas_seed,
   input logic [REF_W-1:0]  ref_seed,
   input logic [WIN_W-1:0]  win_seed
);
   // R3
   a_r3_unpriv_hold: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
      (bus_wr && !bus_priv) |=> ($stable(meas_seed) && $stable(ref_seed) &&
                                 $stable(win_seed) && $stable(en_q)));

   // R4
   a_r4_enable_guard: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
      $rose(en_q) |-> (win_seed >= WIN_W'(MIN_WIN) && meas_seed != '0));

   // R5, R6
   a_r5_fault_latches: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
      fault_c |=> err_q);

   // R8
   a_r8_err_sticky: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
      (err_q && !(bus_wr && bus_priv && bus_addr == 2'd0 && bus_wdata[1])) |=> err_q);

   // R9
   a_r9_quiet_when_off: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
      !en_q |-> !fault_c);
endmodule

bind clk_cmp clk_cmp_chk #(.MEAS_W(MEAS_W), .REF_W(REF_W), .WIN_W(WIN_W), .MIN_WIN(MIN_WIN)) u_chk (
   .ref_clk(ref_clk), .ref_rst_n(ref_rst_n), .bus_wr(bus_wr), .bus_priv(bus_priv),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .en_q(en_q), .err_q(err_q),
   .fault_c(fault_c), .meas_seed(meas_seed), .ref_seed(ref_seed), .win_seed(win_seed)
);

// File: tb/clk_cmp_bench.sv
module clk_cmp_bench;
   logic ref_clk = 1'b0, tst_clk = 1'b0;
   logic ref_rst_n = 1'b0, tst_rst_n = 1'b0;
   logic bus_wr = 1'b0, bus_priv = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        err_flag;
   int checks = 0, failures = 0;
   logic done = 1'b0;

   always #2.5 ref_clk = ~ref_clk;   // 200 MHz reference
   always #3.5 tst_clk = ~tst_clk;   // clock under test

   clk_cmp u_clk_cmp (
      .ref_clk(ref_clk), .ref_rst_n(ref_rst_n), .tst_clk(tst_clk), .tst_rst_n(tst_rst_n),
      .bus_wr(bus_wr), .bus_priv(bus_priv), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .err_flag(err_flag)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic p);
      @(negedge ref_clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_priv = p;
      @(negedge ref_clk);
      bus_wr = 1'b0; bus_priv = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      @(negedge ref_clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge ref_clk);
   endtask

   // disable, clear fault, load measured seed, enable, then observe
   task automatic run_case(input int n1, input logic exp_err, input string req);
      logic [31:0] v;
      wr(2'd0, 32'h0, 1'b1);
      idle(30);
      wr(2'd0, 32'h2, 1'b1);
      wr(2'd1, 32'(n1), 1'b1);
      wr(2'd0, 32'h1, 1'b1);
      idle(440);
      rd(2'd0, v);
      chk(req, {31'b0, v[1]}, {31'b0, exp_err});
      chk(req, {31'b0, err_flag}, {31'b0, exp_err});
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge ref_clk);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : stim
      logic [31:0] v;
      repeat (4) @(negedge ref_clk);
      ref_rst_n = 1'b1; tst_rst_n = 1'b1;
      idle(2);

      // R1: reset state
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), v);
         chk("R1", v, 32'h0);
      end
      chk("R1", {31'b0, err_flag}, 32'h0);

      // R2: readback masking
      wr(2'd1, 32'hFFFF_FFFF, 1'b1); rd(2'd1, v); chk("R2", v, 32'h000F_FFFF);
      wr(2'd2, 32'hFFFF_FFFF, 1'b1); rd(2'd2, v); chk("R2", v, 32'h0000_FFFF);
      wr(2'd3, 32'hFFFF_FFFF, 1'b1); rd(2'd3, v); chk("R2", v, 32'h0000_FFFF);
      wr(2'd1, 32'hABC5_1234, 1'b1); rd(2'd1, v); chk("R2", v, 32'h0005_1234);

      // R3: unprivileged writes dropped
      wr(2'd1, 32'h0000_0007, 1'b0); rd(2'd1, v); chk("R3", v, 32'h0005_1234);
      wr(2'd2, 32'h0000_0009, 1'b0); rd(2'd2, v); chk("R3", v, 32'h0000_FFFF);
      wr(2'd0, 32'h0000_0001, 1'b0); rd(2'd0, v); chk("R3", v, 32'h0);

      // R4: enable guard, window boundary 3 / 4, measured seed zero
      wr(2'd3, 32'd3, 1'b1);
      wr(2'd0, 32'h1, 1'b1); rd(2'd0, v); chk("R4", v & 32'h1, 32'h0);
      wr(2'd3, 32'd4, 1'b1); wr(2'd1, 32'd0, 1'b1);
      wr(2'd0, 32'h1, 1'b1); rd(2'd0, v); chk("R4", v & 32'h1, 32'h0);
      wr(2'd1, 32'd20, 1'b1);
      wr(2'd0, 32'h1, 1'b1); rd(2'd0, v); chk("R4", v & 32'h1, 32'h1);
      wr(2'd0, 32'h0, 1'b1);

      // sweep configuration: reference seed 20, window seed 20
      wr(2'd2, 32'd20, 1'b1);
      wr(2'd3, 32'd20, 1'b1);
      idle(30);
      wr(2'd0, 32'h2, 1'b1);

      // R9: disabled with a bad measured seed raises nothing
      wr(2'd1, 32'd3, 1'b1);
      idle(400);
      chk("R9", {31'b0, err_flag}, 32'h0);

      for (int n = 1; n <= 9; n++)   run_case(n, 1'b1, "R5");
      for (int n = 18; n <= 23; n++) run_case(n, 1'b0, "R7");
      for (int n = 33; n <= 40; n++) run_case(n, 1'b1, "R6");

      // R8: fault is sticky; bit 1 clear does not clear it; bit 1 set does
      run_case(4, 1'b1, "R8");
      wr(2'd0, 32'h0, 1'b1);
      idle(200);
      rd(2'd0, v); chk("R8", v & 32'h2, 32'h2);
      wr(2'd0, 32'h2, 1'b0);
      rd(2'd0, v); chk("R8", v & 32'h2, 32'h2);
      wr(2'd0, 32'h2, 1'b1);
      rd(2'd0, v); chk("R8", v & 32'h2, 32'h0);
      chk("R8", {31'b0, err_flag}, 32'h0);

      // R9: stop mid-run, restart cleanly
      run_case(20, 1'b0, "R9");
      wr(2'd0, 32'h0, 1'b1);
      idle(300);
      chk("R9", {31'b0, err_flag}, 32'h0);
      wr(2'd0, 32'h1, 1'b1);
      idle(600);
      rd(2'd0, v); chk("R9", v, 32'h1);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule